// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block produces the bit clock and the frame (left/right) clock of a stereo audio serial port when the port is clock master. All timing is counted in cycles of the module clock `clk`. A set of static configuration inputs selects five things:

- the bit-clock divide ratio, chosen from a fixed table of codes;
- the frame length in bit clocks, as a power of two;
- the polarity of each clock;
- the framing format: I2S, left-justified, right-justified or a one-bit DSP frame pulse;
- whether the block is master or slave.

Besides the two clocks, the block gives a one-cycle strobe at the start of each frame. This strobe lets a neighbouring shift register load the next sample pair.

The block counts bit indexes 0 to L-1 within a frame of L bit clocks. The left channel occupies the first half of the frame and the right channel the second. Every bit starts with the BCLK low phase (before inversion), and the bit index advances at the end of the high phase. Configuration changes are taken in only at a frame boundary, so no shortened clock period is ever produced. In slave mode the output enable is low, and both clocks rest at their idle levels.

Top module: `asp_clkgen`

## Requirements
- R1: Each BCLK low phase and each high phase lasts R module-clock cycles. R comes from the 4-bit code `cfg_div_code` as follows: 0→1, 1→2, 2→4, 3→6, 4→8, 5→12, 6→16, 7→24, 8→32, 9→48, 10→64, 11→96, 12→128, 13→192. Each frame begins at the start of an uninverted low phase.
- R2: Codes 14 and 15 of `cfg_div_code` behave as R = 1.
- R3: A length code N of 0 to 4 on `cfg_len_code` gives a frame of 16·2^N BCLK periods. Codes 5, 6 and 7 give 256.
- R4: With `cfg_bclk_inv` = 1, BCLK is the complement of its normal waveform. This also holds for its idle level.
- R5: With `cfg_lrck_pol` = 1, LRCK has normal polarity, as R6 to R8 describe. With 0, LRCK is the complement of that waveform.
- R6: Format code 0 (I2S): the normal-polarity LRCK is high for bit indexes L/2-1 through L-2 and low for all others. It therefore changes one BCLK before each channel's first bit.
- R7: Format codes 1 and 2 (left- and right-justified): the normal-polarity LRCK is high for bit indexes L/2 through L-1. It therefore changes together with each channel's first bit.
- R8: Format code 3 (DSP): the normal-polarity LRCK is high only during bit index 0 of each frame.
- R9: The configuration inputs are taken in only in the last cycle of a frame, or while the block is not running. A change at any other time leaves the current frame untouched.
- R10: `frame_stb_o` is high for exactly the first module-clock cycle of every frame.
- R11: One cycle after `cfg_master` goes to 0, the following hold, and they keep holding while it stays 0: `clk_oe_o` and `frame_stb_o` are 0, BCLK equals `cfg_bclk_inv`, and LRCK equals the inverse of `cfg_lrck_pol`. When `cfg_master` returns to 1, a new frame starts on the next cycle.
- R12: While `rst_n` is low, the outputs are at their idle levels as in R11. When `rst_n` rises with `cfg_master` at 1, the first frame starts at the first clock edge after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low reset |
| cfg_master | input | 1 | 1: generate the clocks, 0: stay idle and undriven |
| cfg_bclk_inv | input | 1 | Bit-clock inversion |
| cfg_lrck_pol | input | 1 | Frame-clock polarity, 1 = normal, 0 = inverted |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP |
| cfg_div_code | input | 4 | Bit-clock divide code |
| cfg_len_code | input | 3 | Frame-length code |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock |
| clk_oe_o | output | 1 | High while the clocks are being driven |
| frame_stb_o | output | 1 | One-cycle start-of-frame strobe |

## Verification
The hardest behaviour to reach is a configuration change that lands in the middle of a running frame. It must stay invisible until the boundary and then take effect exactly on the first cycle of the next frame. To exercise this, the stimulus moves through the divide codes, the lengths, the formats and the polarities one frame at a time. For every frame of that sweep, it drives the inputs to unrelated values halfway through, and then to the next setting two cycles before the boundary. Each cycle of the old frame is compared against its original settings, and each cycle of the new frame against the new ones. Leaving master mode and re-entering it, and a reset asserted mid-frame, are driven at arbitrary points within a frame.

// File: rtl/asp_clkgen_pkg.sv
package asp_clkgen_pkg;

  localparam int DIV_W  = 4;
  localparam int LEN_W  = 3;
  localparam int HALF_W = 8;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } asp_fmt_e;

  typedef struct packed {
    logic               bclk_inv;
    logic               lrck_pol;
    asp_fmt_e           fmt;
    logic [DIV_W-1:0]   div_code;
    logic [LEN_W-1:0]   len_code;
  } asp_cfg_t;

  // Cycles per BCLK phase for a divide code; reserved codes fall back to 1.
  function automatic logic [HALF_W-1:0] div_ratio(input logic [DIV_W-1:0] code);
    logic [HALF_W-1:0] r;
    case (code)
      4'd0:    r = 8'd1;
      4'd1:    r = 8'd2;
      4'd2:    r = 8'd4;
      4'd3:    r = 8'd6;
      4'd4:    r = 8'd8;
      4'd5:    r = 8'd12;
      4'd6:    r = 8'd16;
      4'd7:    r = 8'd24;
      4'd8:    r = 8'd32;
      4'd9:    r = 8'd48;
      4'd10:   r = 8'd64;
      4'd11:   r = 8'd96;
      4'd12:   r = 8'd128;
      4'd13:   r = 8'd192;
      default: r = 8'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/asp_cfg_hold.sv
module asp_cfg_hold
  import asp_clkgen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  asp_cfg_t live,
  output asp_cfg_t held
);

  asp_cfg_t held_q;
  asp_cfg_t held_d;

  always_comb begin
    held_d = held_q;
    if (load) held_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign held = held_q;

endmodule

// File: rtl/asp_bit_timer.sv
module asp_bit_timer #(
  parameter int HALF_W = 8,
  parameter int BIT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [HALF_W-1:0] ratio,
  input  logic [BIT_W-1:0]  last_bit,
  output logic [HALF_W-1:0] half_q,
  output logic [HALF_W-1:0] half_d,
  output logic              phase_q,
  output logic              phase_d,
  output logic [BIT_W-1:0]  bit_q,
  output logic [BIT_W-1:0]  bit_d,
  output logic              frame_end
);

  logic half_end;
  logic bit_end;

  always_comb begin
    half_end  = (half_q == ratio - 1'b1);
    bit_end   = half_end & phase_q;
    frame_end = adv & bit_end & (bit_q == last_bit);
    half_d    = '0;
    phase_d   = 1'b0;
    bit_d     = '0;
    if (adv) begin
      half_d  = half_end ? '0 : half_q + 1'b1;
      phase_d = phase_q ^ half_end;
      if (bit_end) bit_d = (bit_q == last_bit) ? '0 : bit_q + 1'b1;
      else         bit_d = bit_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= '0;
      phase_q <= 1'b0;
      bit_q   <= '0;
    end else begin
      half_q  <= half_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
    end
  end

  assert_half_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (half_q < ratio));

  assert_bit_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (bit_q <= last_bit));

endmodule

// File: rtl/asp_lrck_shape.sv
module asp_lrck_shape
  import asp_clkgen_pkg::*;
#(
  parameter int BIT_W = 8
) (
  input  logic             run,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic [BIT_W-1:0] last_bit,
  input  asp_fmt_e         fmt,
  input  logic             pol,
  output logic             level
);

  logic [BIT_W-1:0] mid;
  logic             raw;

  always_comb begin
    mid = last_bit >> 1;
    case (fmt)
      FMT_I2S: raw = (bit_idx >= mid) && (bit_idx != last_bit);
      FMT_LJ,
      FMT_RJ:  raw = (bit_idx > mid);
      default: raw = (bit_idx == '0);
    endcase
    level = run ? (raw ^ ~pol) : ~pol;
  end

endmodule

// File: rtl/asp_clkgen.sv
module asp_clkgen
  import asp_clkgen_pkg::*;
#(
  parameter int LEN_BASE_LOG2 = 4,
  parameter int LEN_MAX_CODE  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_bclk_inv,
  input  logic             cfg_lrck_pol,
  input  logic [1:0]       cfg_fmt,
  input  logic [DIV_W-1:0] cfg_div_code,
  input  logic [LEN_W-1:0] cfg_len_code,
  output logic             bclk_o,
  output logic             lrck_o,
  output logic             clk_oe_o,
  output logic             frame_stb_o
);

  localparam int BIT_W = LEN_BASE_LOG2 + LEN_MAX_CODE;

  function automatic logic [BIT_W-1:0] last_of(input logic [LEN_W-1:0] code);
    logic [LEN_W-1:0] c;
    logic [BIT_W:0]   span;
    c    = (int'(code) > LEN_MAX_CODE) ? LEN_W'(LEN_MAX_CODE) : code;
    span = (BIT_W+1)'(1) << (LEN_BASE_LOG2 + int'(c));
    return BIT_W'(span - 1'b1);
  endfunction

  asp_cfg_t          live_cfg;
  asp_cfg_t          cfg_q;
  asp_cfg_t          cfg_nx;
  logic              run_q;
  logic              run_d;
  logic              adv;
  logic              capture;
  logic [HALF_W-1:0] ratio;
  logic [BIT_W-1:0]  last_q;
  logic [BIT_W-1:0]  last_nx;
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] half_d;
  logic              phase_q;
  logic              phase_d;
  logic [BIT_W-1:0]  bit_q;
  logic [BIT_W-1:0]  bit_d;
  logic              frame_end;
  logic              lrck_d;
  logic              bclk_d;
  logic              stb_d;
  logic              bclk_q;
  logic              lrck_q;
  logic              stb_q;

  always_comb begin
    live_cfg.bclk_inv = cfg_bclk_inv;
    live_cfg.lrck_pol = cfg_lrck_pol;
    live_cfg.fmt      = asp_fmt_e'(cfg_fmt);
    live_cfg.div_code = cfg_div_code;
    live_cfg.len_code = cfg_len_code;
  end

  // Running state and the settings of the frame in progress
  always_comb begin
    run_d   = cfg_master;
    adv     = run_q & cfg_master;
    ratio   = div_ratio(cfg_q.div_code);
    last_q  = last_of(cfg_q.len_code);
    capture = ~run_q | frame_end;
    cfg_nx  = capture ? live_cfg : cfg_q;
    last_nx = last_of(cfg_nx.len_code);
  end

  asp_bit_timer #(
    .HALF_W (HALF_W),
    .BIT_W  (BIT_W)
  ) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .ratio     (ratio),
    .last_bit  (last_q),
    .half_q    (half_q),
    .half_d    (half_d),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .bit_q     (bit_q),
    .bit_d     (bit_d),
    .frame_end (frame_end)
  );

  asp_cfg_hold hold_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (capture),
    .live  (live_cfg),
    .held  (cfg_q)
  );

  asp_lrck_shape #(
    .BIT_W (BIT_W)
  ) shape_i (
    .run      (run_d),
    .bit_idx  (bit_d),
    .last_bit (last_nx),
    .fmt      (cfg_nx.fmt),
    .pol      (cfg_nx.lrck_pol),
    .level    (lrck_d)
  );

  // Output flops take the level of the state being entered
  always_comb begin
    bclk_d = phase_d ^ cfg_nx.bclk_inv;
    stb_d  = run_d & (half_d == '0) & ~phase_d & (bit_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      bclk_q <= bclk_d;
      lrck_q <= lrck_d;
      stb_q  <= stb_d;
    end
  end

  assign bclk_o      = run_q ? bclk_q : cfg_bclk_inv;
  assign lrck_o      = run_q ? lrck_q : ~cfg_lrck_pol;
  assign clk_oe_o    = run_q;
  assign frame_stb_o = stb_q;

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (half_q != '0 || phase_q || bit_q != '0)) |-> $stable(cfg_q));

  assert_stb_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

  assert_stb_at_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (run_q && half_q == '0 && !phase_q && bit_q == '0));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !stb_q);

  assert_dsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cfg_q.fmt == FMT_DSP && bit_q != '0) |-> (lrck_q == ~cfg_q.lrck_pol));

  assert_bclk_turn_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && bclk_q != $past(bclk_q)) |-> (half_q == '0));

endmodule

// File: tb/asp_clkgen_tb_top.sv
module asp_clkgen_tb_top;

  logic       clk;
  logic       rst_n;
  logic       m;
  logic       binv;
  logic       pol;
  logic [1:0] fmt;
  logic [3:0] dc;
  logic [2:0] lc;
  logic       bclk;
  logic       lrck;
  logic       oe;
  logic       stb;

  int    n_chk;
  int    n_fail;
  int    cur_dc, cur_lc, cur_fmt, cur_binv, cur_pol;
  string cur_tag;

  asp_clkgen dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_master   (m),
    .cfg_bclk_inv (binv),
    .cfg_lrck_pol (pol),
    .cfg_fmt      (fmt),
    .cfg_div_code (dc),
    .cfg_len_code (lc),
    .bclk_o       (bclk),
    .lrck_o       (lrck),
    .clk_oe_o     (oe),
    .frame_stb_o  (stb)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  function automatic int ratio_of(int c);
    if (c == 0 || c >= 14) return 1;
    if (c == 1) return 2;
    return ((c % 2) ? 6 : 4) << ((c - 2) / 2);
  endfunction

  function automatic int len_of(int c);
    return 16 << ((c > 4) ? 4 : c);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic set_live(int d, int l, int f, int bi, int p);
    dc   = 4'(d);
    lc   = 3'(l);
    fmt  = 2'(f);
    binv = 1'(bi);
    pol  = 1'(p);
  endtask

  // Compare k0..k0+n-1 of the current frame model, one sample per negedge
  task automatic run_win(int k0, int n, string tag);
    for (int i = 0; i < n; i++) begin
      int k, r, len, ph, b, half, raw, eb, el, es;
      k    = k0 + i;
      r    = ratio_of(cur_dc);
      len  = len_of(cur_lc);
      ph   = k % (2 * r);
      b    = (k / (2 * r)) % len;
      half = len / 2;
      case (cur_fmt)
        0:       raw = (((b + 1) % len) >= half) ? 1 : 0;
        1, 2:    raw = (b >= half) ? 1 : 0;
        default: raw = (b == 0) ? 1 : 0;
      endcase
      eb = ((ph >= r) ? 1 : 0) ^ cur_binv;
      el = raw ^ (cur_pol ? 0 : 1);
      es = ((k % (2 * r * len)) == 0) ? 1 : 0;
      check(tag, "bclk", int'(bclk), eb);
      check(tag, "lrck", int'(lrck), el);
      check(tag, "strobe R10", int'(stb), es);
      check(tag, "oe R11", int'(oe), 1);
      @(negedge clk);
    end
  endtask

  // Check the current frame; disturb the inputs mid-frame; present the next setting
  task automatic frame_then(int d, int l, int f, int bi, int p, string tag);
    int per;
    per = 2 * ratio_of(cur_dc) * len_of(cur_lc);
    run_win(0, per / 2, cur_tag);
    set_live((d + 7) % 16, l ^ 5, f ^ 2, bi ^ 1, p ^ 1);
    run_win(per / 2, per / 2 - 2, "R9");
    set_live(d, l, f, bi, p);
    run_win(per - 2, 2, "R9");
    cur_dc = d; cur_lc = l; cur_fmt = f; cur_binv = bi; cur_pol = p;
    cur_tag = tag;
  endtask

  task automatic idle_check(string tag, int bi, int p);
    check(tag, "idle bclk", int'(bclk), bi);
    check(tag, "idle lrck", int'(lrck), p ? 0 : 1);
    check(tag, "idle oe", int'(oe), 0);
    check(tag, "idle strobe", int'(stb), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #3800us;
    n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    m      = 1'b1;
    set_live(0, 0, 0, 0, 1);
    cur_dc = 0; cur_lc = 0; cur_fmt = 0; cur_binv = 0; cur_pol = 1;
    cur_tag = "R12";
    repeat (3) @(negedge clk);
    idle_check("R12", 0, 1);
    set_live(0, 0, 0, 1, 0);
    @(negedge clk);
    idle_check("R12 R4 R5", 1, 0);
    set_live(0, 0, 0, 0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: every divide code, 16-bit frames
    frame_then(1, 0, 1, 0, 1, "R1");
    for (int d = 2; d < 16; d++) begin
      if (d >= 14) frame_then(d, 0, 1, 0, 1, "R2");
      else         frame_then(d, 0, 1, 0, 1, "R1");
    end

    // R3: every length code including the clamped ones
    for (int l = 0; l < 8; l++) frame_then(0, l, 1, 0, 1, "R3");

    // R6 / R7 / R8: framing formats
    frame_then(1, 2, 0, 0, 1, "R6");
    frame_then(1, 2, 1, 0, 1, "R7");
    frame_then(1, 2, 2, 0, 1, "R7");
    frame_then(1, 2, 3, 0, 1, "R8");
    frame_then(0, 1, 3, 1, 0, "R8");

    // R4 / R5: polarities
    frame_then(1, 0, 0, 1, 1, "R4");
    frame_then(1, 0, 0, 0, 0, "R5");
    frame_then(2, 0, 1, 1, 0, "R5");
    frame_then(1, 0, 2, 1, 0, "R4");
    frame_then(0, 0, 0, 0, 1, "R11");

    // R11: leave master mode mid-frame, idle follows live polarity, re-enter
    run_win(0, 10, cur_tag);
    m = 1'b0;
    @(negedge clk);
    idle_check("R11", 0, 1);
    set_live(3, 1, 3, 1, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      idle_check("R11", 1, 0);
    end
    m = 1'b1;
    cur_dc = 3; cur_lc = 1; cur_fmt = 3; cur_binv = 1; cur_pol = 0;
    @(negedge clk);
    run_win(0, 37, "R11");

    // R12: reset in the middle of a frame, then restart from bit 0
    rst_n = 1'b0;
    #1ns;
    idle_check("R12", 1, 0);
    repeat (2) @(negedge clk);
    idle_check("R12", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_win(0, 2 * ratio_of(3) * len_of(1) + 1, "R12");

    finish_run();
  end

endmodule